// File: doc/BRIEF.md
# Noise-Shaped Dithered PWM Generator

This block turns a 12-bit duty command, typically from a current controller, into a pulse-width modulated output. The carrier period is 450 clock cycles, so one period resolves only about 9 bits of duty. The upper 9 command bits set a coarse on-time in clock cycles. The lower 3 bits go into a first-order error-feedback accumulator, a single residual register with one adder around the quantizer. When that accumulator carries, the coarse on-time of that period grows by one cycle. Averaged over many periods, the duty follows the full 12-bit command, and the dither pattern stays at high frequency.

The duty applied in each period is held between a programmable floor and ceiling, which keeps the bridge out of its unusable regions near 0% and 100%. The residual is not updated while a limit is active. The duty and the residual change only at a period boundary, so a command that changes mid-period never produces a runt pulse.

A two-state machine drives the output. The state register holds the output phase, and a separate process decodes the output pin from it. PH_ON drives the output high and PH_OFF drives it low. The transitions are:
- PH_ON to PH_OFF when the next counter value reaches the applied duty.
- PH_OFF to PH_ON at the period wrap when the newly loaded duty is non-zero.
- PH_ON stays in PH_ON through the wrap when the duty equals the full period.
- PH_OFF stays in PH_OFF through the wrap when the duty is zero.
- Reset enters PH_ON if the floor is non-zero, and PH_OFF otherwise.

Top module: `dither_pwm`

## Requirements
- R1: The period counter runs 0 to 449 and wraps. `period_start` is high for exactly one cycle per period, the cycle in which the counter is 0, so successive strobes are 450 cycles apart.
- R2: In each period, `pwm_out` is high for the first D cycles (counter values 0 to D-1) and low for the rest, where D is the duty applied in that period. There is never a second rising edge within one period.
- R3: The coarse duty is `duty_cmd[11:3]` and the fine part is `duty_cmd[2:0]`. At each period start, the fine part is added to a 3-bit residual, and a carry out of bit 2 adds one cycle to that period's duty. Each unclamped period's duty is therefore the coarse value or the coarse value plus one.
- R4: With a constant command and no limit active, the total high time over any 8 consecutive periods equals `duty_cmd` cycles.
- R5: When the coarse value plus the carry exceeds `duty_hi`, the applied duty is `duty_hi`.
- R6: When the coarse value plus the carry is below `duty_lo`, the applied duty is `duty_lo`.
- R7: While a limit is active, the residual is held rather than updated. A command pinned at the ceiling therefore stays at exactly `duty_hi` every period, and a later in-range command again meets R4.
- R8: A command change in mid-period does not alter the current period's duty. It takes effect at the next period start.
- R9: Synchronous reset clears the residual and the counter and loads the duty with `duty_lo`. During reset, `period_start` is 1 and `pwm_out` is 1 if `duty_lo` is non-zero. The first period after reset has duty `duty_lo`. With the residual cleared, a fine part of 4 gives no carry in the first dithered period and a carry in the second.
- R10: A duty of 0 keeps `pwm_out` low for the whole period. A duty of 450 keeps it high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_cmd | input | 12 | Duty command in 1/8-cycle units of on-time |
| duty_lo | input | 9 | Minimum applied duty, in clock cycles |
| duty_hi | input | 9 | Maximum applied duty, in clock cycles (at most 450) |
| pwm_out | output | 1 | PWM waveform |
| period_start | output | 1 | High in the first cycle of each carrier period |

## Verification
Both outputs are decoded from registers, so they follow the counter in the cycle after each clock edge. A new command or new limits first appear in the period that begins at the next wrap edge after they are applied. The bench drives its inputs on falling edges, steps at least one falling edge, and then waits for the next falling edge at which `period_start` is high. Every period it measures is therefore one whose duty was loaded after the stimulus. It then samples exactly 450 falling edges per period. The first period after reset, and the period that contains a mid-period command change, are counted from their own first cycle so that the deferred load can be seen.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    typedef enum logic {
        PH_OFF = 1'b0,
        PH_ON  = 1'b1
    } pwm_phase_e;

endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
    parameter int PERIOD = 450,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap,
    output logic             at_zero
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_comb begin
        wrap    = (cnt == LAST);
        at_zero = (cnt == '0);
        if (rst || wrap) cnt_nxt = '0;
        else             cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt <= cnt_nxt;
    end

    // R1: counter never leaves its range
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < PERIOD);

    // R1: last count is followed by zero
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/dpwm_quant.sv
module dpwm_quant #(
    parameter int CMD_W  = 12,
    parameter int FINE_W = 3,
    localparam int DUTY_W = CMD_W - FINE_W
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [FINE_W-1:0] resid,
    input  logic [DUTY_W-1:0] lim_lo,
    input  logic [DUTY_W-1:0] lim_hi,
    output logic [DUTY_W-1:0] duty_nxt,
    output logic [FINE_W-1:0] resid_nxt,
    output logic              clamp_hi,
    output logic              clamp_lo
);

    logic [FINE_W:0] fine_sum;
    logic [DUTY_W:0] raw;

    always_comb begin
        fine_sum = {1'b0, resid} + {1'b0, cmd[FINE_W-1:0]};
        raw      = {1'b0, cmd[CMD_W-1:FINE_W]} + {{DUTY_W{1'b0}}, fine_sum[FINE_W]};
        clamp_hi = (raw > {1'b0, lim_hi});
        clamp_lo = !clamp_hi && (raw < {1'b0, lim_lo});
        if (clamp_hi)      duty_nxt = lim_hi;
        else if (clamp_lo) duty_nxt = lim_lo;
        else               duty_nxt = raw[DUTY_W-1:0];
        resid_nxt = (clamp_hi || clamp_lo) ? resid : fine_sum[FINE_W-1:0];
    end

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm #(
    parameter int CMD_W  = 12,
    parameter int FINE_W = 3,
    parameter int PERIOD = 450
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CMD_W-1:0]          duty_cmd,
    input  logic [CMD_W-FINE_W-1:0]   duty_lo,
    input  logic [CMD_W-FINE_W-1:0]   duty_hi,
    output logic                      pwm_out,
    output logic                      period_start
);

    import dpwm_pkg::*;

    localparam int DUTY_W = CMD_W - FINE_W;
    localparam int CNT_W  = $clog2(PERIOD);

    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              wrap, at_zero;
    logic [DUTY_W-1:0] duty_q, duty_d, q_duty;
    logic [FINE_W-1:0] resid_q, resid_d, q_resid;
    logic              q_clamp_hi, q_clamp_lo;
    pwm_phase_e        state, state_nxt;

    dpwm_counter #(.PERIOD(PERIOD)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap),
        .at_zero (at_zero)
    );

    dpwm_quant #(.CMD_W(CMD_W), .FINE_W(FINE_W)) u_quant (
        .cmd       (duty_cmd),
        .resid     (resid_q),
        .lim_lo    (duty_lo),
        .lim_hi    (duty_hi),
        .duty_nxt  (q_duty),
        .resid_nxt (q_resid),
        .clamp_hi  (q_clamp_hi),
        .clamp_lo  (q_clamp_lo)
    );

    // period-boundary loading of duty and residual
    always_comb begin
        if (rst) begin
            duty_d  = duty_lo;
            resid_d = '0;
        end else if (wrap) begin
            duty_d  = q_duty;
            resid_d = q_resid;
        end else begin
            duty_d  = duty_q;
            resid_d = resid_q;
        end
        state_nxt = (int'(cnt_nxt) < int'(duty_d)) ? PH_ON : PH_OFF;
    end

    always_ff @(posedge clk) begin
        duty_q  <= duty_d;
        resid_q <= resid_d;
    end

    // state register
    always_ff @(posedge clk) begin
        state <= state_nxt;
    end

    // output decode
    always_comb begin
        unique case (state)
            PH_ON:   pwm_out = 1'b1;
            PH_OFF:  pwm_out = 1'b0;
            default: pwm_out = 1'b0;
        endcase
        period_start = at_zero;
    end

    // R8: duty and residual change only at the wrap
    a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(duty_q) && $stable(resid_q)));

    // R5 / R6: loaded duty lies within the limits
    a_r5_duty_in_limits: assert property (@(posedge clk) disable iff (rst)
        (wrap && (duty_lo <= duty_hi)) |=>
        ((duty_q >= $past(duty_lo)) && (duty_q <= $past(duty_hi))));

    // R7: residual frozen while a limit acts
    a_r7_no_windup: assert property (@(posedge clk) disable iff (rst)
        (wrap && (q_clamp_hi || q_clamp_lo)) |=> $stable(resid_q));

    // R2: output low once counter reaches the duty
    a_r2_low_after_duty: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) >= int'(duty_q)) |-> !pwm_out);

    // R2: output high before the duty is reached
    a_r2_high_before_duty: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) < int'(duty_q)) |-> pwm_out);

endmodule

// File: tb/dither_pwm_tb.sv
`timescale 1ns/1ps
module dither_pwm_tb;

    localparam int PERIOD = 450;
    localparam int NV = 9;

    // min, max, command, expected 8-period high total
    localparam int V_LO  [NV] = '{0,   0,    0,    0,   0,    0,    30,  0,    0};
    localparam int V_HI  [NV] = '{450, 450,  450,  450, 450,  440,  450, 300,  300};
    localparam int V_CMD [NV] = '{1000, 1237, 2047, 0,  3600, 4000, 100, 2404, 2396};
    localparam int V_EXP [NV] = '{1000, 1237, 2047, 0,  3600, 3520, 240, 2400, 2396};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] duty_cmd = '0;
    logic [8:0]  duty_lo = 9'd20;
    logic [8:0]  duty_hi = 9'd450;
    logic        pwm_out, period_start;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dither_pwm u_dut (
        .clk          (clk),
        .rst          (rst),
        .duty_cmd     (duty_cmd),
        .duty_lo      (duty_lo),
        .duty_hi      (duty_hi),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge where period_start is high; ends at the next one.
    task automatic measure_period(output int highs, output int starts, output int rises);
        logic prev = 1'b0;
        highs = 0; starts = 0; rises = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_out) highs++;
            if (period_start) starts++;
            if (i > 0 && pwm_out && !prev) rises++;
            prev = pwm_out;
            @(negedge clk);
        end
    endtask

    task automatic sync_start();
        @(negedge clk);
        while (!period_start) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, s, r, tot, lo, hi;
        duty_cmd = 12'd324;   // coarse 40, fine 4
        repeat (4) @(negedge clk);
        // R9: reset state
        check(period_start == 1'b1, "R9 strobe in reset", int'(period_start), 1);
        check(pwm_out == 1'b1, "R9 output in reset", int'(pwm_out), 1);
        rst = 1'b0;
        measure_period(h, s, r);
        check(h == 20, "R9 first period at floor", h, 20);
        check(s == 1, "R1 one strobe per period", s, 1);
        measure_period(h, s, r);
        check(h == 40, "R9 cleared residual no carry", h, 40);
        measure_period(h, s, r);
        check(h == 41, "R9 carry on second period", h, 41);

        // table walk
        for (int v = 0; v < NV; v++) begin
            duty_lo  = 9'(V_LO[v]);
            duty_hi  = 9'(V_HI[v]);
            duty_cmd = 12'(V_CMD[v]);
            sync_start();
            tot = 0;
            lo = V_EXP[v] / 8;
            hi = lo + ((V_EXP[v] % 8) != 0 ? 1 : 0);
            for (int p = 0; p < 8; p++) begin
                measure_period(h, s, r);
                tot += h;
                check(h >= lo && h <= hi, "R3 per-period duty", h, lo);
                check(s == 1, "R1 strobe spacing", s, 1);
                check(r == 0, "R2 single pulse", r, 0);
            end
            if (v == 5)      check(tot == V_EXP[v], "R5 ceiling", tot, V_EXP[v]);
            else if (v == 6) check(tot == V_EXP[v], "R6 floor", tot, V_EXP[v]);
            else if (v == 7) check(tot == V_EXP[v], "R7 held at ceiling", tot, V_EXP[v]);
            else if (v == 3 || v == 4) check(tot == V_EXP[v], "R10 full-range duty", tot, V_EXP[v]);
            else             check(tot == V_EXP[v], "R4 eight-period total", tot, V_EXP[v]);
        end

        // R8: mid-period change deferred
        duty_lo = 9'd0; duty_hi = 9'd450; duty_cmd = 12'd1600;
        sync_start();
        measure_period(h, s, r);
        h = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (i == 100) duty_cmd = 12'd800;
            if (pwm_out) h++;
            @(negedge clk);
        end
        check(h == 200, "R8 current period unchanged", h, 200);
        measure_period(h, s, r);
        check(h == 100, "R8 new command next period", h, 100);

        // R9: reset again mid-run
        duty_lo = 9'd0; duty_cmd = 12'd1000;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(period_start == 1'b1, "R9 strobe in reset", int'(period_start), 1);
        check(pwm_out == 1'b0, "R9 zero floor output low", int'(pwm_out), 0);
        rst = 1'b0;
        measure_period(h, s, r);
        check(h == 0, "R9 first period at zero floor", h, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule